// File: doc/BRIEF.md
# Indirect Register Window for a Disc-Data Decoder

This block gives a host sixteen byte-wide registers of a disc-data decoder through two small ports: a 4-bit index register and an 8-bit data port. The host loads the index once, then issues a run of reads or writes. Most accesses move the index on by one, so consecutive registers can be walked without reloading it. A few registers act as strobes and leave the index where it is, so the host can hit them again.

Writes fill the transfer byte count, transfer address, write address, block pointer, three control bytes, a sub-output byte and interface control. They also trigger a transfer, acknowledge the end of a transfer, or soft-reset the window. Reads return the decoder's command byte, interface status, byte count, four header bytes, pointer, write address and four status bytes. The block records which decode-result registers the host has read. When the host finally reads the last status byte with the right enables set, that byte changes to 0x80, which marks the result as consumed. Sector decoding and the transfer engine sit outside. They take the stored values from the output pins and supply the header, status and command bytes on input pins.

Top module: `cdcw_regwin`

## Requirements
- R1: After power-on reset: interface status 0xFF, write address 4704 (0x1260), index 0, and zero in byte count, transfer address, pointer, control bytes, sub-output, interface control, status byte 3, busy flag and read-tracking record.
- R2: A data write (wr_en) stores into the register at the current index. It advances the index by one for indices 0-5 and 8-13. Indices 6, 7, 14 and 15 leave the index unchanged.
- R3: A read (rd_en) advances the index by one for indices 0-14 and leaves it at 15. A host index load (addr_we) in the same cycle as a read or write wins: the access uses the old index and the index then takes addr_wdata.
- R4: Write map: 0 sub-output, 1 interface control, 2/3 byte count low/high, 4/5 transfer address low/high, 8/9 write address low/high, 10/11/12... control byte 0 at 10, control byte 1 at 11, pointer low/high at 12/13, control byte 2 at 14. ctrl_word packs {control2, control1, control0}.
- R5: Read map: 0 cmd_in, 1 interface status, 2/3 byte count low/high, 4-7 hdr_in bytes 0-3 (byte n = hdr_in[8n+7:8n]), 8/9 pointer low/high, 10/11 write address low/high, 12-14 stat_in bytes 0-2 (same packing), 15 status byte 3.
- R6: A write to index 6 while interface-control bit 1 is set raises xfer_busy, clears interface-status bit 3 and pulses xfer_start for one cycle. With bit 1 clear it changes nothing.
- R7: A write to index 1 with data bit 1 clear zeroes the byte count, drops xfer_busy and sets interface-status bit 3.
- R8: A write to index 7 sets interface-status bit 6.
- R9: A read of index 15 sets interface-status bit 5 and returns the value status byte 3 held before the read.
- R10: Reads of indices 1, 4-9 and 12-14 are recorded. A read of index 15 sets status byte 3 to 0x80 when control-0 bit 7 and interface-control bit 1... interface-control bit 5 are both set and all of 1, 4, 5, 6, 7, 8, 9, 12, 13 and 14 have been read (mask 0x73F2).
- R11: A write to index 15 restores every R1 value except the index, which stays unchanged, and clears the read record.
- R12: Read data appears on rd_data with rd_valid high in the cycle after rd_en. If wr_en and rd_en coincide, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Load the register index |
| addr_wdata | input | 4 | New register index |
| wr_en | input | 1 | Write data to the indexed register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read the indexed register |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | rd_data holds a fresh read |
| reg_addr | output | 4 | Current register index |
| cmd_in | input | 8 | Decoder command byte |
| hdr_in | input | 32 | Decoder header bytes 0-3 |
| stat_in | input | 24 | Decoder status bytes 0-2 |
| sub_out | output | 8 | Sub-output byte |
| if_ctrl | output | 8 | Interface control |
| if_stat | output | 8 | Interface status |
| byte_cnt | output | 16 | Transfer byte count |
| xfer_addr | output | 16 | Transfer address |
| wr_addr | output | 16 | Write address |
| ptr | output | 16 | Block pointer |
| ctrl_word | output | 24 | {control2, control1, control0} |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_start | output | 1 | One-cycle transfer trigger pulse |

## Verification
The assertions assume the host never raises wr_en and rd_en in the same cycle. Under that assumption the index stepping and side-effect properties describe one access per cycle. They also assume cmd_in, hdr_in and stat_in are held stable across an access, so a read's expected byte is well defined. The bench drives exactly one of index load, write or read per operation, except in one directed case that pairs a read with an index load to exercise the precedence rule. It changes the decoder inputs only between operations.

// File: rtl/cdcw_pkg.sv
package cdcw_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] IX_SUB    = 4'd0;
  localparam logic [IDX_W-1:0] IX_IFC    = 4'd1;
  localparam logic [IDX_W-1:0] IX_CNT_L  = 4'd2;
  localparam logic [IDX_W-1:0] IX_CNT_H  = 4'd3;
  localparam logic [IDX_W-1:0] IX_XA_L   = 4'd4;
  localparam logic [IDX_W-1:0] IX_XA_H   = 4'd5;
  localparam logic [IDX_W-1:0] IX_TRIG   = 4'd6;
  localparam logic [IDX_W-1:0] IX_ACK    = 4'd7;
  localparam logic [IDX_W-1:0] IX_WA_L   = 4'd8;
  localparam logic [IDX_W-1:0] IX_WA_H   = 4'd9;
  localparam logic [IDX_W-1:0] IX_C0     = 4'd10;
  localparam logic [IDX_W-1:0] IX_C1     = 4'd11;
  localparam logic [IDX_W-1:0] IX_PT_L   = 4'd12;
  localparam logic [IDX_W-1:0] IX_PT_H   = 4'd13;
  localparam logic [IDX_W-1:0] IX_C2     = 4'd14;
  localparam logic [IDX_W-1:0] IX_LAST   = 4'd15;

  // index advances after a write unless the slot is a strobe
  function automatic logic wr_advances(input logic [IDX_W-1:0] ix);
    return !(ix == IX_TRIG || ix == IX_ACK || ix == IX_C2 || ix == IX_LAST);
  endfunction

  function automatic logic rd_advances(input logic [IDX_W-1:0] ix);
    return ix != IX_LAST;
  endfunction

  // reads recorded for the consumed-result handshake
  function automatic logic rd_tracked(input logic [IDX_W-1:0] ix);
    return ix == 4'd1 || (ix >= 4'd4 && ix <= 4'd9) || (ix >= 4'd12 && ix <= 4'd14);
  endfunction
endpackage

// File: rtl/cdcw_index.sv
module cdcw_index #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= load_val;
    else if (step) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/cdcw_track.sv
module cdcw_track #(
  parameter int unsigned AW   = 4,
  parameter logic [(1<<AW)-1:0] MASK = 16'h73F2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mark,
  input  logic [AW-1:0] idx,
  output logic          all_seen
);
  localparam int unsigned N = 1 << AW;
  logic [N-1:0] seen;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         seen[g] <= 1'b0;
      else if (clr)                       seen[g] <= 1'b0;
      else if (mark && idx == AW'(g))     seen[g] <= 1'b1;
    end
  end

  assign all_seen = (seen & MASK) == MASK;
endmodule

// File: rtl/cdcw_rdmux.sv
module cdcw_rdmux #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic [AW-1:0]   idx,
  input  logic [DW-1:0]   cmd,
  input  logic [DW-1:0]   ifs,
  input  logic [2*DW-1:0] cnt,
  input  logic [4*DW-1:0] hdr,
  input  logic [2*DW-1:0] pt,
  input  logic [2*DW-1:0] wa,
  input  logic [3*DW-1:0] st,
  input  logic [DW-1:0]   st3,
  output logic [DW-1:0]   dout
);
  always_comb begin
    unique case (idx)
      4'd0:  dout = cmd;
      4'd1:  dout = ifs;
      4'd2:  dout = cnt[DW-1:0];
      4'd3:  dout = cnt[2*DW-1:DW];
      4'd4:  dout = hdr[DW-1:0];
      4'd5:  dout = hdr[2*DW-1:DW];
      4'd6:  dout = hdr[3*DW-1:2*DW];
      4'd7:  dout = hdr[4*DW-1:3*DW];
      4'd8:  dout = pt[DW-1:0];
      4'd9:  dout = pt[2*DW-1:DW];
      4'd10: dout = wa[DW-1:0];
      4'd11: dout = wa[2*DW-1:DW];
      4'd12: dout = st[DW-1:0];
      4'd13: dout = st[2*DW-1:DW];
      4'd14: dout = st[3*DW-1:2*DW];
      default: dout = st3;
    endcase
  end
endmodule

// File: rtl/cdcw_regwin.sv
module cdcw_regwin
  import cdcw_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 4,
  parameter logic [15:0] WA_RESET = 16'd4704,
  parameter logic [15:0] DONE_MASK = 16'h73F2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_we,
  input  logic [AW-1:0]   addr_wdata,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   cmd_in,
  input  logic [4*DW-1:0] hdr_in,
  input  logic [3*DW-1:0] stat_in,
  output logic [DW-1:0]   sub_out,
  output logic [DW-1:0]   if_ctrl,
  output logic [DW-1:0]   if_stat,
  output logic [2*DW-1:0] byte_cnt,
  output logic [2*DW-1:0] xfer_addr,
  output logic [2*DW-1:0] wr_addr,
  output logic [2*DW-1:0] ptr,
  output logic [3*DW-1:0] ctrl_word,
  output logic            xfer_busy,
  output logic            xfer_start
);
  localparam int unsigned HW = 2 * DW;
  localparam logic [DW-1:0] DONE_VAL = {1'b1, {(DW-1){1'b0}}};

  logic acc_wr, acc_rd, step, soft_rst, all_seen, done_ok;
  logic [DW-1:0] c0, c1, c2, st3, mux_out;

  assign acc_wr   = wr_en;
  assign acc_rd   = rd_en & ~wr_en;
  assign soft_rst = acc_wr && reg_addr == IX_LAST;
  assign step     = (acc_wr && wr_advances(reg_addr)) || (acc_rd && rd_advances(reg_addr));
  assign done_ok  = c0[7] && if_ctrl[5] && all_seen;
  assign ctrl_word = {c2, c1, c0};

  cdcw_index #(.AW(AW)) u_index (
    .clk(clk), .rst_n(rst_n), .load(addr_we), .load_val(addr_wdata),
    .step(step), .idx(reg_addr)
  );

  cdcw_track #(.AW(AW), .MASK(DONE_MASK)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .mark(acc_rd && rd_tracked(reg_addr)), .idx(reg_addr), .all_seen(all_seen)
  );

  cdcw_rdmux #(.DW(DW), .AW(AW)) u_rdmux (
    .idx(reg_addr), .cmd(cmd_in), .ifs(if_stat), .cnt(byte_cnt), .hdr(hdr_in),
    .pt(ptr), .wa(wr_addr), .st(stat_in), .st3(st3), .dout(mux_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= mux_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_out <= '0; if_ctrl <= '0; if_stat <= '1;
      byte_cnt <= '0; xfer_addr <= '0; wr_addr <= HW'(WA_RESET); ptr <= '0;
      c0 <= '0; c1 <= '0; c2 <= '0; st3 <= '0;
      xfer_busy <= 1'b0; xfer_start <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      if (acc_wr) begin
        unique case (reg_addr)
          IX_SUB:   sub_out <= wr_data;
          IX_IFC: begin
            if_ctrl <= wr_data;
            if (!wr_data[1]) begin
              byte_cnt   <= '0;
              xfer_busy  <= 1'b0;
              if_stat[3] <= 1'b1;
            end
          end
          IX_CNT_L: byte_cnt[DW-1:0]   <= wr_data;
          IX_CNT_H: byte_cnt[HW-1:DW]  <= wr_data;
          IX_XA_L:  xfer_addr[DW-1:0]  <= wr_data;
          IX_XA_H:  xfer_addr[HW-1:DW] <= wr_data;
          IX_TRIG: begin
            if (if_ctrl[1]) begin
              if_stat[3] <= 1'b0;
              xfer_busy  <= 1'b1;
              xfer_start <= 1'b1;
            end
          end
          IX_ACK:   if_stat[6] <= 1'b1;
          IX_WA_L:  wr_addr[DW-1:0]  <= wr_data;
          IX_WA_H:  wr_addr[HW-1:DW] <= wr_data;
          IX_C0:    c0 <= wr_data;
          IX_C1:    c1 <= wr_data;
          IX_PT_L:  ptr[DW-1:0]  <= wr_data;
          IX_PT_H:  ptr[HW-1:DW] <= wr_data;
          IX_C2:    c2 <= wr_data;
          default: begin
            sub_out <= '0; if_ctrl <= '0; if_stat <= '1;
            byte_cnt <= '0; xfer_addr <= '0; wr_addr <= HW'(WA_RESET); ptr <= '0;
            c0 <= '0; c1 <= '0; c2 <= '0; st3 <= '0;
            xfer_busy <= 1'b0;
          end
        endcase
      end else if (acc_rd && reg_addr == IX_LAST) begin
        if_stat[5] <= 1'b1;
        if (done_ok) st3 <= DONE_VAL;
      end
    end
  end
endmodule

// File: rtl/cdcw_regwin_chk.sv
module cdcw_regwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_we,
  input logic [3:0]  addr_wdata,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic        rd_en,
  input logic        rd_valid,
  input logic [3:0]  reg_addr,
  input logic [7:0]  if_stat,
  input logic [15:0] byte_cnt,
  input logic [15:0] wr_addr,
  input logic        xfer_busy,
  input logic        xfer_start
);
  // host issues one access per cycle (R12)
  p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);

  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_we && (reg_addr == 4'd6 || reg_addr == 4'd7 ||
     reg_addr == 4'd14 || reg_addr == 4'd15)) |=> $stable(reg_addr));

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !addr_we && reg_addr != 4'd15) |=> reg_addr == $past(reg_addr) + 4'd1);

  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> reg_addr == $past(addr_wdata));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (xfer_busy && !if_stat[3]));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 4'd1 && !wr_data[1]) |=> (!xfer_busy && byte_cnt == 16'd0 && if_stat[3]));

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 4'd7) |=> if_stat[6]);

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 4'd15) |=> (if_stat == 8'hFF && wr_addr == 16'd4704 && !xfer_busy));
endmodule

bind cdcw_regwin cdcw_regwin_chk u_chk (.*);

// File: tb/sim_cdcw_regwin.sv
module sim_cdcw_regwin;
  logic clk = 0, rst_n = 0;
  logic addr_we = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr_wdata = 0;
  logic [7:0] wr_data = 0, cmd_in = 0;
  logic [31:0] hdr_in = 0;
  logic [23:0] stat_in = 0;
  logic [7:0] rd_data, sub_out, if_ctrl, if_stat;
  logic rd_valid, xfer_busy, xfer_start;
  logic [3:0] reg_addr;
  logic [15:0] byte_cnt, xfer_addr, wr_addr, ptr;
  logic [23:0] ctrl_word;

  always #10 clk = ~clk;

  cdcw_regwin u0 (.*);

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference model
  logic [3:0]  m_ix;
  logic [7:0]  m_sub, m_ifc, m_ifs, m_c0, m_c1, m_c2, m_st3;
  logic [15:0] m_cnt, m_xa, m_wa, m_pt, m_seen;
  logic        m_busy, m_start;

  task automatic model_reset(input bit keep_ix);
    if (!keep_ix) m_ix = 0;
    m_sub = 0; m_ifc = 0; m_ifs = 8'hFF; m_c0 = 0; m_c1 = 0; m_c2 = 0; m_st3 = 0;
    m_cnt = 0; m_xa = 0; m_wa = 16'd4704; m_pt = 0; m_seen = 0; m_busy = 0;
  endtask

  task automatic model_write(input logic [7:0] d);
    m_start = 0;
    case (m_ix)
      0: m_sub = d;
      1: begin m_ifc = d; if (!d[1]) begin m_cnt = 0; m_busy = 0; m_ifs[3] = 1; end end
      2: m_cnt[7:0] = d;   3: m_cnt[15:8] = d;
      4: m_xa[7:0] = d;    5: m_xa[15:8] = d;
      6: if (m_ifc[1]) begin m_ifs[3] = 0; m_busy = 1; m_start = 1; end
      7: m_ifs[6] = 1;
      8: m_wa[7:0] = d;    9: m_wa[15:8] = d;
      10: m_c0 = d;        11: m_c1 = d;
      12: m_pt[7:0] = d;   13: m_pt[15:8] = d;
      14: m_c2 = d;
      default: model_reset(1);
    endcase
    if (!(m_ix inside {4'd6, 4'd7, 4'd14, 4'd15})) m_ix = m_ix + 1;
  endtask

  function automatic logic [7:0] model_rdval(input logic [3:0] ix);
    case (ix)
      0: return cmd_in;       1: return m_ifs;
      2: return m_cnt[7:0];   3: return m_cnt[15:8];
      4: return hdr_in[7:0];  5: return hdr_in[15:8];
      6: return hdr_in[23:16]; 7: return hdr_in[31:24];
      8: return m_pt[7:0];    9: return m_pt[15:8];
      10: return m_wa[7:0];   11: return m_wa[15:8];
      12: return stat_in[7:0]; 13: return stat_in[15:8];
      14: return stat_in[23:16];
      default: return m_st3;
    endcase
  endfunction

  task automatic model_read(output logic [7:0] v);
    m_start = 0;
    v = model_rdval(m_ix);
    if (m_ix == 1 || (m_ix >= 4 && m_ix <= 9) || (m_ix >= 12 && m_ix <= 14)) m_seen[m_ix] = 1;
    if (m_ix == 15) begin
      m_ifs[5] = 1;
      if (m_c0[7] && m_ifc[5] && ((m_seen & 16'h73F2) == 16'h73F2)) m_st3 = 8'h80;
    end else m_ix = m_ix + 1;
  endtask

  function automatic logic [117:0] act_vec();
    return {reg_addr, if_stat, byte_cnt, xfer_addr, wr_addr, ptr, ctrl_word,
            sub_out, if_ctrl, xfer_busy, xfer_start};
  endfunction
  function automatic logic [117:0] exp_vec();
    return {m_ix, m_ifs, m_cnt, m_xa, m_wa, m_pt, m_c2, m_c1, m_c0,
            m_sub, m_ifc, m_busy, m_start};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, 128'(act_vec()), 128'(exp_vec()));
  endtask

  task automatic finish_op();
    @(posedge clk);
    @(negedge clk);
    addr_we = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic op_load(input logic [3:0] a, input string tag);
    addr_we = 1; addr_wdata = a;
    finish_op();
    m_ix = a; m_start = 0;
    check_state(tag);
  endtask

  task automatic op_write(input logic [7:0] d, input string tag);
    wr_en = 1; wr_data = d;
    finish_op();
    model_write(d);
    check_state(tag);
  endtask

  task automatic op_read(input string tag);
    logic [7:0] e;
    rd_en = 1;
    finish_op();
    model_read(e);
    check({tag, " data"}, {rd_valid, rd_data}, {1'b1, e});
    check_state(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog act=%0d exp=<150000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    model_reset(0); m_start = 0;
    cmd_in = 8'h3C; hdr_in = 32'h44332211; stat_in = 24'hC0B0A0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");
    check("R1 reset if_stat/wr_addr", {if_stat, wr_addr}, {8'hFF, 16'd4704});

    // stream writes through 0..5 then 8..13
    op_load(4'd0, "R3 load");
    for (int i = 0; i < 6; i++) op_write(8'(8'h10 + i), "R2 R4 stream");
    op_load(4'd8, "R3 load");
    for (int i = 0; i < 6; i++) op_write(8'(8'hA0 + i), "R2 R4 stream");
    check("R4 wr_addr", 128'(wr_addr), 128'(16'hA1A0));
    op_write(8'h5A, "R2 R4 c2 hold");
    check("R2 hold at 14", 128'(reg_addr), 128'(4'd14));

    // trigger with enable clear: no effect
    op_load(4'd1, "R3 load"); op_write(8'h00, "R7 abort");
    op_load(4'd6, "R3 load"); op_write(8'hFF, "R6 trigger disabled");
    check("R6 no busy", {xfer_busy, if_stat[3]}, 2'b01);
    op_load(4'd2, "R3 load"); op_write(8'h34, "R4 cnt"); op_write(8'h12, "R4 cnt");
    op_load(4'd1, "R3 load"); op_write(8'h22, "R4 ifc");
    op_load(4'd6, "R3 load"); op_write(8'h00, "R6 trigger");
    check("R6 start", {xfer_start, xfer_busy, if_stat[3]}, 3'b110);
    op_load(4'd1, "R3 load"); op_write(8'h20, "R7 abort");
    check("R7 abort", {xfer_busy, if_stat[3], byte_cnt}, {2'b01, 16'h0000});
    op_load(4'd7, "R3 load"); op_write(8'h00, "R8 ack");

    // consumed-result handshake
    op_load(4'd10, "R3 load"); op_write(8'h80, "R4 c0");
    op_load(4'd1, "R3 load"); op_write(8'h22, "R4 ifc");
    op_load(4'd1, "R3 load"); op_read("R5 R10 ifs");
    op_load(4'd4, "R3 load");
    for (int i = 4; i < 15; i++) op_read("R5 R10 walk");
    op_read("R9 first st3");
    check("R9 old value", 128'(rd_data), 128'(8'h00));
    check("R9 bit5", 128'(if_stat[5]), 128'(1'b1));
    op_read("R10 st3 done");
    check("R10 st3 0x80", 128'(rd_data), 128'(8'h80));

    // read plus load in same cycle: load wins
    op_load(4'd2, "R3 load");
    rd_en = 1; addr_we = 1; addr_wdata = 4'd9;
    finish_op();
    model_read(v); m_ix = 4'd9;
    check("R3 precedence data", {rd_valid, rd_data}, {1'b1, v});
    check_state("R3 precedence");

    // soft reset keeps index
    op_load(4'd15, "R3 load"); op_write(8'h00, "R11 soft reset");
    check("R11 idx kept", 128'(reg_addr), 128'(4'd15));

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (n % 50 == 0) begin
        cmd_in = 8'($urandom); hdr_in = $urandom; stat_in = 24'($urandom);
      end
      if (k < 2)      op_load(4'($urandom), "R3 rnd load");
      else if (k < 6) op_write(8'($urandom), "R2 R4 R6 R7 R8 R11 rnd write");
      else            op_read("R5 R9 R10 R12 rnd read");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule